// File: doc/BRIEF.md
# Host-Side Parallel Peripheral Port Controller

This block lets a host processor run a shared 8-bit peripheral bus on which the host is always the master. Each host I/O request names one of five transfer kinds. Three of them put a byte on the bus and mark it with their own low-going strobe: address, command or data. The other two sample the bus while their own low-going gate line is asserted: status or data. Peripherals only answer and never start anything, so the block has no arbitration and no request input from the bus side.

The data lines are open-drain with external pull-ups. The block never drives a line high. For each bit it gives a pull-low enable, and it reads back the resolved bus levels. Bus polarity is active low. A 1 bit in the host byte pulls its line low. A line read low is returned as a 1 bit. A sixth control line, an active-low bus reset, is held asserted for a fixed time after the block leaves reset.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the host must hold its request, and it has no effect. Completion is a single-cycle `done` pulse with read data. That pulse has no back-pressure.

Top module: `pport_host`

## Requirements
- R1: While `rst_n` is low, and for the first 8 clocks after it rises, `brst_n` is 0, `req_ready` is 0 and no request is taken. After that `brst_n` and `req_ready` are 1. All strobe and gate lines are 1 and `bus_pull` is 0 throughout this period.
- R2: Operation codes on `req_op` are 0 = address out (`adr_stb_n`), 1 = command out (`cmd_stb_n`), 2 = data out (`dat_stb_n`), 3 = status in (`sts_gate_n`) and 4 = data in (`din_gate_n`). A transfer asserts only the line named by its code.
- R3: An output transfer latches `req_wdata` at acceptance. From the next cycle `bus_pull` equals that byte, where bit=1 means pull the line low. The byte is present for 2 cycles before the strobe falls.
- R4: The output strobe stays low for exactly 4 cycles, and `bus_pull` does not change while it is low.
- R5: After the strobe rises, `bus_pull` keeps the byte for 2 more cycles. In the following cycle `bus_pull` is 0, `busy` is 0 and `done` is 1 for exactly one cycle.
- R6: An input transfer holds its gate low for exactly 4 cycles, starting the cycle after acceptance, and `bus_pull` stays 0 for the whole transfer.
- R7: On the last gate cycle the block samples `bus_in` and inverts it. The result appears on `rd_data` in the `done` cycle right after the gate rises. `rd_data` changes only in a `done` cycle.
- R8: `busy` is 1 from the cycle after acceptance until the `done` cycle. While `busy` is 1, `req_ready` is 0 and a request held on the interface has no effect on the running transfer.
- R9: Codes 5, 6 and 7 are consumed when taken but cause no bus activity, no `busy` and no `done`.
- R10: At most one strobe or gate line is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 3 | Transfer code (see R2) |
| req_wdata | input | 8 | Byte for output transfers |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte from the last input transfer |
| bus_in | input | 8 | Resolved bus line levels |
| bus_pull | output | 8 | Per-line pull-low enable |
| adr_stb_n | output | 1 | Address-out strobe, active low |
| cmd_stb_n | output | 1 | Command-out strobe, active low |
| dat_stb_n | output | 1 | Data-out strobe, active low |
| sts_gate_n | output | 1 | Status-in gate, active low |
| din_gate_n | output | 1 | Data-in gate, active low |
| brst_n | output | 1 | Bus reset, active low |

## Verification
A wrong sequencer state or phase count shows up within one cycle at the control lines. A strobe falls early, stays low for 3 or 5 cycles, or the wrong line moves. Each case is caught on the exact cycle where the bench expects an edge. A bad holding register or missing inversion shows as a wrong `bus_pull` value on the first driven cycle, or as a wrong `rd_data` at the `done` pulse. A broken busy or reset interlock shows as a second transfer, or a gate, during a period where the lines must stay quiet.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam logic [2:0] OP_ADR = 3'd0;
  localparam logic [2:0] OP_CMD = 3'd1;
  localparam logic [2:0] OP_DAT = 3'd2;
  localparam logic [2:0] OP_STS = 3'd3;
  localparam logic [2:0] OP_DIN = 3'd4;
  localparam int N_OSTB  = 3;
  localparam int N_IGATE = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRB,
    ST_HOLD,
    ST_GATE
  } pport_st_e;
endpackage

// File: rtl/pport_brst.sv
module pport_brst #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic ok
);
  localparam int W = $clog2(CYC + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (cnt_q != W'(CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign ok = (cnt_q == W'(CYC));
endmodule

// File: rtl/pport_seq.sv
module pport_seq
  import pport_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int STRB_CYC  = 4,
  parameter int HOLD_CYC  = 2,
  parameter int GATE_CYC  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                req_valid,
  input  logic [2:0]          req_op,
  output logic                req_ready,
  output logic                busy,
  output logic                cap,
  output logic                drv_en,
  output logic [N_OSTB-1:0]   ostb,
  output logic [N_IGATE-1:0]  igate,
  output logic                sample,
  output logic                done
);
  localparam int MAX_A = (SETUP_CYC > STRB_CYC) ? SETUP_CYC : STRB_CYC;
  localparam int MAX_B = (HOLD_CYC > GATE_CYC) ? HOLD_CYC : GATE_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXC + 1);

  pport_st_e   st_q;
  logic [2:0]  op_q;
  logic [CW-1:0] cnt_q, last_cnt;
  logic        accept, req_out, req_in, last;

  assign req_ready = en && (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign req_out   = (req_op <= OP_DAT);
  assign req_in    = (req_op == OP_STS) || (req_op == OP_DIN);

  always_comb begin
    case (st_q)
      ST_SETUP: last_cnt = CW'(SETUP_CYC - 1);
      ST_STRB:  last_cnt = CW'(STRB_CYC - 1);
      ST_HOLD:  last_cnt = CW'(HOLD_CYC - 1);
      default:  last_cnt = CW'(GATE_CYC - 1);
    endcase
  end
  assign last = (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (accept) begin
            op_q <= req_op;
            if (req_out)     st_q <= ST_SETUP;
            else if (req_in) st_q <= ST_GATE;
          end
        end
        ST_SETUP, ST_STRB: begin
          if (last) begin
            cnt_q <= '0;
            st_q  <= (st_q == ST_SETUP) ? ST_STRB : ST_HOLD;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_HOLD, ST_GATE: begin
          if (last) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
            done  <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign cap    = accept && req_out;
  assign drv_en = (st_q == ST_SETUP) || (st_q == ST_STRB) || (st_q == ST_HOLD);
  assign sample = (st_q == ST_GATE) && last;

  for (genvar i = 0; i < N_OSTB; i++) begin : g_ostb
    assign ostb[i] = (st_q == ST_STRB) && (op_q == OP_ADR + 3'(i));
  end
  for (genvar j = 0; j < N_IGATE; j++) begin : g_igate
    assign igate[j] = (st_q == ST_GATE) && (op_q == OP_STS + 3'(j));
  end
endmodule

// File: rtl/pport_io.sv
module pport_io #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] wdata,
  input  logic          drv_en,
  input  logic          sample,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_pull,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      rd_data <= '0;
    end else begin
      if (cap)    hold_q  <= wdata;
      if (sample) rd_data <= ~bus_in;
    end
  end

  for (genvar b = 0; b < DW; b++) begin : g_pull
    assign bus_pull[b] = drv_en & hold_q[b];
  end
endmodule

// File: rtl/pport_host.sv
module pport_host
  import pport_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int STRB_CYC  = 4,
  parameter int HOLD_CYC  = 2,
  parameter int GATE_CYC  = 4,
  parameter int BRST_CYC  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_pull,
  output logic          adr_stb_n,
  output logic          cmd_stb_n,
  output logic          dat_stb_n,
  output logic          sts_gate_n,
  output logic          din_gate_n,
  output logic          brst_n
);
  logic                bus_ok, cap, drv_en, sample;
  logic [N_OSTB-1:0]   ostb;
  logic [N_IGATE-1:0]  igate;

  pport_brst #(.CYC(BRST_CYC)) u_brst (
    .clk(clk), .rst_n(rst_n), .ok(bus_ok)
  );

  pport_seq #(
    .SETUP_CYC(SETUP_CYC), .STRB_CYC(STRB_CYC),
    .HOLD_CYC(HOLD_CYC), .GATE_CYC(GATE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .en(bus_ok),
    .req_valid(req_valid), .req_op(req_op), .req_ready(req_ready),
    .busy(busy), .cap(cap), .drv_en(drv_en), .ostb(ostb),
    .igate(igate), .sample(sample), .done(done)
  );

  pport_io #(.DW(DW)) u_io (
    .clk(clk), .rst_n(rst_n), .cap(cap), .wdata(req_wdata),
    .drv_en(drv_en), .sample(sample), .bus_in(bus_in),
    .bus_pull(bus_pull), .rd_data(rd_data)
  );

  assign adr_stb_n  = ~ostb[0];
  assign cmd_stb_n  = ~ostb[1];
  assign dat_stb_n  = ~ostb[2];
  assign sts_gate_n = ~igate[0];
  assign din_gate_n = ~igate[1];
  assign brst_n     = bus_ok;
endmodule

// File: rtl/pport_host_chk.sv
module pport_host_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] bus_pull,
  input logic          adr_stb_n,
  input logic          cmd_stb_n,
  input logic          dat_stb_n,
  input logic          sts_gate_n,
  input logic          din_gate_n,
  input logic          brst_n
);
  logic stb_low, gate_low;
  assign stb_low  = !(adr_stb_n && cmd_stb_n && dat_stb_n);
  assign gate_low = !(sts_gate_n && din_gate_n);

  p_quiet_in_brst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !brst_n |-> (!req_ready && !busy && !stb_low && !gate_low));

  p_one_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{adr_stb_n, cmd_stb_n, dat_stb_n, sts_gate_n, din_gate_n}));

  p_pull_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_pull) |-> busy);

  p_data_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_low && $past(stb_low)) |-> $stable(bus_pull));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && bus_pull == '0));

  p_gate_no_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_low |-> (bus_pull == '0));

  p_rd_moves_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
endmodule

bind pport_host pport_host_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
  .done(done), .rd_data(rd_data), .bus_pull(bus_pull),
  .adr_stb_n(adr_stb_n), .cmd_stb_n(cmd_stb_n), .dat_stb_n(dat_stb_n),
  .sts_gate_n(sts_gate_n), .din_gate_n(din_gate_n), .brst_n(brst_n)
);

// File: tb/pport_host_tb.sv
`timescale 1ns/1ps
module pport_host_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_op = 3'd0;
  logic [7:0] req_wdata = 8'h00;
  logic       busy, done;
  logic [7:0] rd_data;
  logic [7:0] bus_in = 8'hFF;
  logic [7:0] bus_pull;
  logic       adr_stb_n, cmd_stb_n, dat_stb_n, sts_gate_n, din_gate_n, brst_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pport_host u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .bus_in(bus_in), .bus_pull(bus_pull),
    .adr_stb_n(adr_stb_n), .cmd_stb_n(cmd_stb_n), .dat_stb_n(dat_stb_n),
    .sts_gate_n(sts_gate_n), .din_gate_n(din_gate_n), .brst_n(brst_n)
  );

  // line vector ordered by operation code: bit k low = line of code k active
  function automatic logic [4:0] lines();
    return {din_gate_n, sts_gate_n, dat_stb_n, cmd_stb_n, adr_stb_n};
  endfunction

  function automatic logic [4:0] line_exp(input logic [2:0] op);
    return ~(5'b00001 << op);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic accept(input logic [2:0] op, input logic [7:0] wd);
    @(negedge clk);
    chk(req_ready === 1'b1, "R8 ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_op = op; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 1'b1; req_op = 3'd0; req_wdata = 8'hFF;
    repeat (3) @(negedge clk);
    chk(brst_n === 1'b0 && bus_pull === 8'h00 && lines() === 5'h1F,
        "R1 in reset", {brst_n, bus_pull, 3'b0, lines()}, 32'h0001F);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      chk(brst_n === 1'b0 && req_ready === 1'b0 && busy === 1'b0 && lines() === 5'h1F,
          "R1 bus reset window", {brst_n, req_ready, busy, lines()}, 32'h1F);
      if (k == 7) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(brst_n === 1'b1 && req_ready === 1'b1, "R1 bus reset end",
        {brst_n, req_ready}, 32'h3);
    chk(busy === 1'b0 && bus_pull === 8'h00, "R1 no transfer taken",
        {busy, bus_pull}, 0);
  endtask

  task automatic t_out(input logic [2:0] op, input logic [7:0] wd);
    accept(op, wd);
    for (int k = 0; k < 2; k++) begin
      chk(bus_pull === wd && lines() === 5'h1F, "R3 setup",
          {bus_pull, 3'b0, lines()}, {wd, 8'h1F});
      chk(busy === 1'b1 && req_ready === 1'b0, "R8 busy", {busy, req_ready}, 2);
      @(negedge clk);
    end
    for (int k = 0; k < 4; k++) begin
      chk(lines() === line_exp(op), "R2 R4 strobe low", lines(), line_exp(op));
      chk(bus_pull === wd, "R4 data steady", bus_pull, wd);
      @(negedge clk);
    end
    for (int k = 0; k < 2; k++) begin
      chk(lines() === 5'h1F && bus_pull === wd, "R5 hold",
          {bus_pull, 3'b0, lines()}, {wd, 8'h1F});
      @(negedge clk);
    end
    chk(done === 1'b1 && busy === 1'b0 && bus_pull === 8'h00, "R5 done",
        {done, busy, bus_pull}, 32'h200);
    @(negedge clk);
    chk(done === 1'b0, "R5 done single", 32'(done), 0);
  endtask

  task automatic t_in(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    bus_in = a;
    accept(op, 8'hA5);
    for (int k = 0; k < 4; k++) begin
      chk(lines() === line_exp(op) && bus_pull === 8'h00, "R2 R6 gate low",
          {bus_pull, 3'b0, lines()}, {8'h00, 3'b0, line_exp(op)});
      if (k == 3) bus_in = b;
      @(negedge clk);
    end
    chk(lines() === 5'h1F && done === 1'b1 && busy === 1'b0, "R6 gate released",
        {done, busy, lines()}, {2'b10, 5'h1F});
    chk(rd_data === ~b, "R7 read inverted", rd_data, ~b);
    bus_in = ~b;
    repeat (3) @(negedge clk);
    chk(rd_data === ~b, "R7 read held", rd_data, ~b);
  endtask

  task automatic t_busy_ignore();
    int gate_seen = 0;
    int stb_cnt = 0;
    accept(3'd2, 8'h3C);
    req_valid = 1'b1; req_op = 3'd4;
    for (int k = 0; k < 8; k++) begin
      if (lines()[4] === 1'b0 || lines()[3] === 1'b0) gate_seen++;
      if (dat_stb_n === 1'b0) stb_cnt++;
      chk(req_ready === 1'b0 && bus_pull === 8'h3C, "R8 held request ignored",
          {req_ready, bus_pull}, 32'h03C);
      if (k == 7) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(gate_seen == 0 && stb_cnt == 4, "R8 transfer unchanged",
        {gate_seen[15:0], stb_cnt[15:0]}, 4);
    chk(done === 1'b1, "R8 done after ignore", 32'(done), 1);
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && lines() === 5'h1F, "R8 nothing started",
        {busy, lines()}, 32'h1F);
  endtask

  task automatic t_bad_op(input logic [2:0] op);
    int act = 0;
    accept(op, 8'hFF);
    for (int k = 0; k < 10; k++) begin
      if (busy !== 1'b0 || done !== 1'b0 || lines() !== 5'h1F || bus_pull !== 8'h00) act++;
      @(negedge clk);
    end
    chk(act == 0, "R9 unused code quiet", act, 0);
  endtask

  task automatic t_back_to_back();
    int multi = 0;
    accept(3'd0, 8'h01);
    for (int k = 0; k < 9; k++) begin
      if ($countones(~lines()) > 1) multi++;
      if (done === 1'b1) begin
        req_valid = 1'b1; req_op = 3'd3; bus_in = 8'h7E;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if ($countones(~lines()) > 1) multi++;
      chk(sts_gate_n === 1'b0, "R8 R10 taken at done cycle", 32'(sts_gate_n), 0);
      @(negedge clk);
    end
    chk(multi == 0, "R10 one line", multi, 0);
    chk(rd_data === 8'h81, "R7 back-to-back read", rd_data, 8'h81);
  endtask

  initial begin
    t_reset();
    t_out(3'd0, 8'hA5);
    t_out(3'd1, 8'h00);
    t_out(3'd2, 8'hFF);
    t_in(3'd3, 8'hF0, 8'h5A);
    t_in(3'd4, 8'h00, 8'hFF);
    t_busy_ignore();
    t_bad_op(3'd5);
    t_bad_op(3'd6);
    t_bad_op(3'd7);
    t_back_to_back();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule